// File: doc/BRIEF.md
# Wake Event Detector for Received Ethernet Frames

This block watches the byte stream of received Ethernet frames and raises a power-management event when it sees a wake condition. There are two kinds of wake condition. The first is a magic sequence: a run of six 0xFF bytes followed by sixteen back-to-back copies of the station's 48-bit address. The second is a frame whose selected bytes match one of four programmable patterns. Each pattern picks up to 64 frame bytes, starting at its own offset, through a 64-bit mask. It then compares a CRC-16 computed over those bytes with a programmed value.

A wake event sets a sticky status flag and records which detector caused it. Software clears both by writing a one, modelled here as a one-cycle clear pulse. The active-low wake pin is pulled low only while the status is set, wake signalling is enabled, and the device is in its deepest power-down state. Receive framing, the frame check sequence and the host bus sit outside this block.

Top module: `wk_detect`

## Requirements
- R1: After synchronous reset, `pme_status` is 0, `wake_src` is 0 and `pme_n` is 1.
- R2: Within one frame, six consecutive 0xFF bytes followed by 96 bytes forming 16 copies of `node_addr` set `pme_status` at the clock edge that takes the last address byte, with `wake_src` = 1. Each copy is sent least significant byte first (`node_addr[7:0]` first, `node_addr[47:40]` last).
- R3: Any byte that breaks the expected address sequence restarts the search: the run count becomes 1 if that byte is 0xFF and 0 otherwise. A frame with a corrupted copy raises no event. Extra 0xFF bytes before the first address byte are tolerated.
- R4: Pattern k (0..3) uses mask `pat_mask[64k+63:64k]`, where bit i selects frame byte `offset+i` (frame byte 0 is the byte carrying `rx_sof`). At the edge that takes the `rx_eof` byte, the pattern matches when a CRC-16 over the selected bytes, in frame order, equals `pat_crc[16k+15:16k]`. The CRC uses polynomial 0x8005, seed 0xFFFF, bits least significant first, and no final inversion. A match sets `pme_status` with `wake_src` = 4+k. Changing an unselected byte does not affect the result.
- R5: `pat_offset[8k+7:8k]` sets the frame byte that mask bit 0 of pattern k refers to, so shifting the offset shifts the bytes that are covered.
- R6: A pattern whose 64-bit mask is all zero never matches.
- R7: When several detectors fire on the same byte, the magic sequence wins over the patterns, and a lower-numbered pattern wins over a higher one.
- R8: `pme_status` stays set across frame ends until a `pme_clr` pulse. While it is set, `wake_src` keeps the first cause. A new event in the same cycle as `pme_clr` leaves the status set and loads the new cause. A clear with no event returns both to 0.
- R9: `pme_n` is 0 exactly when `pme_status`, `pme_en` and `pwr_d3` are all 1.
- R10: A byte carrying `rx_sof` restarts both detectors, so a magic sequence split across two frames raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present |
| rx_sof | input | 1 | Present byte is the first of a frame |
| rx_eof | input | 1 | Present byte is the last of a frame |
| rx_byte | input | 8 | Received byte |
| node_addr | input | 48 | Station address, bits 7:0 sent first |
| pat_offset | input | 32 | Four 8-bit start offsets, pattern k at bits 8k+7:8k |
| pat_crc | input | 64 | Four 16-bit expected CRCs |
| pat_mask | input | 256 | Four 64-bit byte masks |
| pme_en | input | 1 | Wake signalling enable |
| pwr_d3 | input | 1 | Device is in the deepest power-down state |
| pme_clr | input | 1 | Write-one-to-clear pulse for the status |
| pme_status | output | 1 | Sticky wake status |
| wake_src | output | 3 | Cause: 0 none, 1 magic, 4+k pattern k |
| pme_n | output | 1 | Active-low wake pin |

## Verification
The assertions assume that `rx_sof` and `rx_eof` are only meaningful while `rx_valid` is high. They also assume that configuration inputs stay stable while a frame is in flight and that `pme_clr` is a single-cycle pulse. The stimulus drives every byte with `rx_valid` high and holds all framing strobes low between frames. It changes masks, offsets and CRC values only in idle gaps between frames. The stimulus covers clean, corrupted, split and padded magic sequences, selected and unselected byte changes for the patterns, offset shifts, simultaneous hits, and a clear that lands on the same byte as an event.

// File: rtl/wk_pkg.sv
// Package: shared constants and the CRC step used by the pattern matchers.
// Assumes CRC-16 (poly 0x8005) processed least significant bit first, which
// is computed in right-shifting form with the reversed polynomial.
package wk_pkg;
    localparam int          CRC_W     = 16;
    localparam logic [15:0] CRC_SEED  = 16'hFFFF;
    localparam logic [15:0] CRC_RPOLY = 16'hA001;

    // Advance the CRC by one byte, bit 0 of the byte first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_RPOLY;
            else             r = r >> 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/wk_magic.sv
// Module: magic-sequence detector. Counts a run of 0xFF sync bytes, then
// tracks address bytes copy by copy; flags a hit on the final address byte.
// Assumes rx_sof/rx_byte are only meaningful while rx_valid is high.
module wk_magic #(
    parameter int ABYTES   = 6,
    parameter int SYNC_LEN = 6,
    parameter int COPIES   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic                rx_sof,
    input  logic [7:0]          rx_byte,
    input  logic [ABYTES*8-1:0] node_addr,
    output logic                magic_hit
);
    localparam int SYW = $clog2(SYNC_LEN + 1);
    localparam int BW  = (ABYTES > 1) ? $clog2(ABYTES) : 1;
    localparam int CW  = (COPIES > 1) ? $clog2(COPIES) : 1;

    logic [SYW-1:0] sync_q, sync_cur, sync_d;
    logic [BW-1:0]  bidx_q, bidx_cur, bidx_d;
    logic [CW-1:0]  copy_q, copy_cur, copy_d;
    logic [7:0]     want;
    logic           is_ff;

    // Select the address byte expected at the current position.
    always_comb begin
        want = '0;
        for (int i = 0; i < ABYTES; i++)
            if (bidx_cur == BW'(i)) want = node_addr[i*8 +: 8];
    end

    // Next-state logic for the sync run and address tracking.
    always_comb begin
        sync_cur  = rx_sof ? '0 : sync_q;
        bidx_cur  = rx_sof ? '0 : bidx_q;
        copy_cur  = rx_sof ? '0 : copy_q;
        is_ff     = (rx_byte == 8'hFF);
        sync_d    = sync_cur;
        bidx_d    = bidx_cur;
        copy_d    = copy_cur;
        magic_hit = 1'b0;
        if (sync_cur != SYW'(SYNC_LEN)) begin
            sync_d = is_ff ? sync_cur + 1'b1 : '0;
        end else if (rx_byte == want) begin
            if (bidx_cur == BW'(ABYTES - 1)) begin
                bidx_d = '0;
                if (copy_cur == CW'(COPIES - 1)) begin
                    magic_hit = rx_valid;
                    copy_d    = '0;
                    sync_d    = '0;
                end else begin
                    copy_d = copy_cur + 1'b1;
                end
            end else begin
                bidx_d = bidx_cur + 1'b1;
            end
        end else if (!(bidx_cur == '0 && copy_cur == '0 && is_ff)) begin
            bidx_d = '0;
            copy_d = '0;
            sync_d = is_ff ? SYW'(1) : '0;
        end
    end

    // Register the search state on every accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            bidx_q <= '0;
            copy_q <= '0;
        end else if (rx_valid) begin
            sync_q <= sync_d;
            bidx_q <= bidx_d;
            copy_q <= copy_d;
        end
    end

    assert_sync_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q <= SYW'(SYNC_LEN));
    assert_byte_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bidx_q < BW'(ABYTES));
    assert_hit_rearm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        magic_hit |=> (sync_q == '0 && bidx_q == '0 && copy_q == '0));
endmodule

// File: rtl/wk_pattern.sv
// Module: one masked-byte pattern matcher. Tracks the frame byte index,
// folds mask-selected bytes into a CRC-16 and compares at frame end.
// Assumes mask, offset and expected CRC are stable during a frame.
module wk_pattern #(
    parameter int OFFW  = 8,
    parameter int MASKB = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_byte,
    input  logic [OFFW-1:0]  offset,
    input  logic [MASKB-1:0] mask,
    input  logic [15:0]      crc_exp,
    output logic             hit
);
    import wk_pkg::*;
    localparam int RELW = $clog2(MASKB);
    localparam int IDXW = OFFW + RELW + 1;

    logic [IDXW-1:0] idx_q, idx_cur, rel;
    logic            in_win, sel;
    logic [15:0]     crc_q, crc_cur, crc_d;

    // Decide whether the present byte is selected and fold it in.
    always_comb begin
        idx_cur = rx_sof ? '0 : idx_q;
        rel     = idx_cur - IDXW'(offset);
        in_win  = (idx_cur >= IDXW'(offset)) && (rel < IDXW'(MASKB));
        sel     = in_win && mask[rel[RELW-1:0]];
        crc_cur = rx_sof ? CRC_SEED : crc_q;
        crc_d   = sel ? crc16_step(crc_cur, rx_byte) : crc_cur;
        hit     = rx_valid && rx_eof && (|mask) && (crc_d == crc_exp);
    end

    // Hold the running CRC and the saturating byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            crc_q <= CRC_SEED;
        end else if (rx_valid) begin
            crc_q <= crc_d;
            idx_q <= (idx_cur == '1) ? idx_cur : idx_cur + 1'b1;
        end
    end

    assert_sof_reseed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sof && !sel) |=> (crc_q == CRC_SEED));
    assert_index_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sof) |=> (idx_q == IDXW'(1)));
endmodule

// File: rtl/wk_pme.sv
// Module: sticky wake status with cause code. An event sets the status and,
// if none was held or a clear arrives together, loads the new cause.
// Assumes pme_clr is a single-cycle write-one pulse.
module wk_pme #(
    parameter int SRCW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt,
    input  logic [SRCW-1:0] evt_code,
    input  logic            pme_clr,
    output logic            pme_status,
    output logic [SRCW-1:0] wake_src
);
    // Update status and cause; an event takes precedence over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pme_status <= 1'b0;
            wake_src   <= '0;
        end else if (evt) begin
            pme_status <= 1'b1;
            if (!pme_status || pme_clr) wake_src <= evt_code;
        end else if (pme_clr) begin
            pme_status <= 1'b0;
            wake_src   <= '0;
        end
    end

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pme_status && !pme_clr) |=> pme_status);
    assert_cause_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pme_status |-> (wake_src != '0));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pme_clr && !evt) |=> !pme_status);
endmodule

// File: rtl/wk_detect.sv
// Module: top of the wake event detector. One magic-sequence detector and
// NPAT pattern matchers feed a priority encoder and the sticky status.
// Assumes configuration is changed only between frames.
module wk_detect #(
    parameter int NPAT   = 4,
    parameter int OFFW   = 8,
    parameter int MASKB  = 64,
    parameter int ABYTES = 6,
    parameter int SRCW   = $clog2(NPAT) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic                  rx_sof,
    input  logic                  rx_eof,
    input  logic [7:0]            rx_byte,
    input  logic [ABYTES*8-1:0]   node_addr,
    input  logic [NPAT*OFFW-1:0]  pat_offset,
    input  logic [NPAT*16-1:0]    pat_crc,
    input  logic [NPAT*MASKB-1:0] pat_mask,
    input  logic                  pme_en,
    input  logic                  pwr_d3,
    input  logic                  pme_clr,
    output logic                  pme_status,
    output logic [SRCW-1:0]       wake_src,
    output logic                  pme_n
);
    localparam int PATW = SRCW - 1;

    logic            magic_hit;
    logic [NPAT-1:0] pat_hit;
    logic            evt;
    logic [SRCW-1:0] evt_code;

    wk_magic #(.ABYTES(ABYTES), .SYNC_LEN(6), .COPIES(16)) u_magic (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_byte(rx_byte), .node_addr(node_addr), .magic_hit(magic_hit)
    );

    for (genvar k = 0; k < NPAT; k++) begin : g_pat
        wk_pattern #(.OFFW(OFFW), .MASKB(MASKB)) u_pat (
            .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
            .rx_eof(rx_eof), .rx_byte(rx_byte),
            .offset(pat_offset[k*OFFW +: OFFW]),
            .mask(pat_mask[k*MASKB +: MASKB]),
            .crc_exp(pat_crc[k*16 +: 16]),
            .hit(pat_hit[k])
        );
    end

    // Priority encode: magic first, then the lowest-numbered pattern.
    always_comb begin
        evt_code = '0;
        for (int k = NPAT - 1; k >= 0; k--)
            if (pat_hit[k]) evt_code = {1'b1, PATW'(k)};
        if (magic_hit) evt_code = SRCW'(1);
        evt = magic_hit || (|pat_hit);
    end

    wk_pme #(.SRCW(SRCW)) u_pme (
        .clk(clk), .rst_n(rst_n), .evt(evt), .evt_code(evt_code),
        .pme_clr(pme_clr), .pme_status(pme_status), .wake_src(wake_src)
    );

    // Drive the wake pin only in the deep power state with signalling enabled.
    assign pme_n = !(pme_status && pme_en && pwr_d3);

    assert_pin_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pme_n |-> (pme_status && pwr_d3 && pme_en));
    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pme_status);
endmodule

// File: tb/sim_wk_detect.sv
module sim_wk_detect;
    localparam int CLK_PERIOD = 10;
    localparam int NPAT = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]   rx_byte = '0;
    logic [47:0]  node_addr = 48'h5EA3107C2291;
    logic [31:0]  pat_offset = '0;
    logic [63:0]  pat_crc = '0;
    logic [255:0] pat_mask = '0;
    logic         pme_en = 1'b0, pwr_d3 = 1'b0, pme_clr = 1'b0;
    logic         pme_status, pme_n;
    logic [2:0]   wake_src;

    int    total = 0, bad = 0;
    string cur_req = "R1";
    logic [7:0] txq[$];
    logic [7:0] mframe[$];

    // reference state
    logic       m_status = 1'b0;
    logic [2:0] m_src = '0;
    int         m_sync = 0, m_pos = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wk_detect u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_byte(rx_byte), .node_addr(node_addr),
        .pat_offset(pat_offset), .pat_crc(pat_crc), .pat_mask(pat_mask),
        .pme_en(pme_en), .pwr_d3(pwr_d3), .pme_clr(pme_clr),
        .pme_status(pme_status), .wake_src(wake_src), .pme_n(pme_n)
    );

    function automatic logic [15:0] rev16(input logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[15-i];
        return r;
    endfunction

    // CRC-16 0x8005, LSB first, done in left-shifting form on a reversed register
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic fb;
        r = rev16(c);
        for (int j = 0; j < 8; j++) begin
            fb = r[15] ^ d[j];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h8005;
        end
        return rev16(r);
    endfunction

    function automatic logic [15:0] frame_crc(input logic [7:0] q[$], input int k);
        logic [15:0] c;
        int off;
        c = 16'hFFFF;
        off = int'(pat_offset[k*8 +: 8]);
        for (int i = 0; i < 64; i++)
            if (pat_mask[k*64 + i] && (off + i) < q.size()) c = ref_crc(c, q[off + i]);
        return c;
    endfunction

    // behavioural model, advanced on every edge, compared a quarter period later
    always @(posedge clk) begin
        logic mhit;
        logic [2:0] code;
        logic [7:0] b, want;
        if (!rst_n) begin
            m_status = 1'b0; m_src = '0; m_sync = 0; m_pos = 0; mframe.delete();
        end else begin
            mhit = 1'b0; code = '0;
            if (rx_valid) begin
                b = rx_byte;
                if (rx_sof) begin m_sync = 0; m_pos = 0; mframe.delete(); end
                mframe.push_back(b);
                if (m_sync < 6) begin
                    m_sync = (b == 8'hFF) ? m_sync + 1 : 0;
                end else begin
                    want = node_addr[(m_pos % 6)*8 +: 8];
                    if (b == want) begin
                        m_pos++;
                        if (m_pos == 96) begin mhit = 1'b1; m_pos = 0; m_sync = 0; end
                    end else if (!(m_pos == 0 && b == 8'hFF)) begin
                        m_pos = 0;
                        m_sync = (b == 8'hFF) ? 1 : 0;
                    end
                end
                if (rx_eof)
                    for (int k = NPAT - 1; k >= 0; k--)
                        if (pat_mask[k*64 +: 64] != 0 && frame_crc(mframe, k) == pat_crc[k*16 +: 16])
                            code = 3'(4 + k);
                if (mhit) code = 3'd1;
            end
            if (code != 0) begin
                if (!m_status || pme_clr) m_src = code;
                m_status = 1'b1;
            end else if (pme_clr) begin
                m_status = 1'b0; m_src = '0;
            end
        end
        #(CLK_PERIOD/4);
        total++;
        if (pme_status !== m_status || wake_src !== m_src ||
            pme_n !== !(m_status && pme_en && pwr_d3)) begin
            bad++;
            $display("FAIL %s cycle compare: status=%b src=%0d pin=%b expected status=%b src=%0d pin=%b",
                     cur_req, pme_status, wake_src, pme_n, m_status, m_src,
                     !(m_status && pme_en && pwr_d3));
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_frame(input bit clr_last);
        for (int i = 0; i < txq.size(); i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_byte = txq[i];
            rx_sof = (i == 0); rx_eof = (i == txq.size() - 1);
            pme_clr = clr_last && (i == txq.size() - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; pme_clr = 1'b0;
    endtask

    task automatic clear_pulse();
        @(negedge clk); pme_clr = 1'b1;
        @(negedge clk); pme_clr = 1'b0;
    endtask

    task automatic push_ff(input int n);
        for (int i = 0; i < n; i++) txq.push_back(8'hFF);
    endtask

    task automatic push_copies(input int n);
        for (int c = 0; c < n; c++)
            for (int i = 0; i < 6; i++) txq.push_back(node_addr[i*8 +: 8]);
    endtask

    task automatic push_data(input int n, input int seed);
        for (int i = 0; i < n; i++) txq.push_back(8'((i * 7 + seed) & 8'hFF));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 status", pme_status, 0); chk("R1 src", wake_src, 0); chk("R1 pin", pme_n, 1);

        // R2: clean magic sequence after junk bytes
        cur_req = "R2";
        txq.delete(); txq.push_back(8'h00); txq.push_back(8'h12);
        push_ff(6); push_copies(16); push_data(5, 1);
        send_frame(0);
        chk("R2 status", pme_status, 1); chk("R2 src", wake_src, 1);
        cur_req = "R8"; clear_pulse();
        chk("R8 cleared", pme_status, 0); chk("R8 src cleared", wake_src, 0);

        // R3: corrupted tenth copy
        cur_req = "R3";
        txq.delete(); push_ff(6); push_copies(9);
        txq.push_back(node_addr[7:0]); txq.push_back(8'h00); push_copies(6); push_data(4, 3);
        send_frame(0);
        chk("R3 broken copy", pme_status, 0);
        // R3: extra sync bytes tolerated
        txq.delete(); push_ff(9); push_copies(16);
        send_frame(0);
        chk("R3 long sync", wake_src, 1);
        clear_pulse();

        // R10: sequence split across frames
        cur_req = "R10";
        txq.delete(); push_ff(6); push_copies(8); send_frame(0);
        txq.delete(); push_copies(8); push_data(3, 2); send_frame(0);
        chk("R10 split", pme_status, 0);

        // R4: pattern 2 with offset 12
        cur_req = "R4";
        pat_offset[16 +: 8] = 8'd12;
        pat_mask[128 +: 64] = 64'h8000_0102_0000_0023;
        txq.delete(); push_data(90, 3);
        pat_crc[32 +: 16] = frame_crc(txq, 2);
        send_frame(0);
        chk("R4 match src", wake_src, 6);
        clear_pulse();
        txq[12 + 2] = txq[12 + 2] ^ 8'h55; txq[11] = 8'hAA;
        send_frame(0);
        chk("R4 unselected change", wake_src, 6);
        clear_pulse();
        txq[12 + 5] = txq[12 + 5] ^ 8'h01;
        send_frame(0);
        chk("R4 selected change", pme_status, 0);
        // R5: shifting the offset moves the covered bytes
        cur_req = "R5";
        txq.delete(); push_data(90, 3);
        pat_offset[16 +: 8] = 8'd13;
        send_frame(0);
        chk("R5 shifted offset", pme_status, 0);
        txq.delete(); txq.push_back(8'h77); push_data(89, 3);
        send_frame(0);
        chk("R5 shifted frame", wake_src, 6);
        clear_pulse();
        pat_mask[128 +: 64] = '0;

        // R6: zero mask with seed-valued CRC never matches
        cur_req = "R6";
        pat_crc[48 +: 16] = 16'hFFFF;
        txq.delete(); push_data(20, 9); send_frame(0);
        chk("R6 zero mask", pme_status, 0);

        // R7: magic and patterns 0,1 on the same final byte
        cur_req = "R7";
        txq.delete(); push_ff(6); push_copies(16);
        pat_mask[0 +: 64] = 64'hF; pat_mask[64 +: 64] = 64'hF;
        pat_offset[0 +: 8] = 8'd0; pat_offset[8 +: 8] = 8'd6;
        pat_crc[0 +: 16] = frame_crc(txq, 0); pat_crc[16 +: 16] = frame_crc(txq, 1);
        send_frame(0);
        chk("R7 magic first", wake_src, 1);
        clear_pulse();
        pat_mask[0 +: 64] = '0;
        pat_mask[192 +: 64] = 64'h0000_0001_0000_0101; pat_offset[24 +: 8] = 8'd2;
        txq.delete(); push_data(70, 5);
        pat_crc[16 +: 16] = frame_crc(txq, 1); pat_crc[48 +: 16] = frame_crc(txq, 3);
        send_frame(0);
        chk("R7 lower pattern", wake_src, 5);

        // R8: status sticky; first cause held
        cur_req = "R8";
        txq.delete(); push_ff(6); push_copies(16); push_data(2, 0);
        send_frame(0);
        chk("R8 held cause", wake_src, 5); chk("R8 held status", pme_status, 1);
        // R9: pin gating
        cur_req = "R9";
        @(negedge clk); pme_en = 1'b1; pwr_d3 = 1'b0; #1 chk("R9 not d3", pme_n, 1);
        @(negedge clk); pme_en = 1'b1; pwr_d3 = 1'b1; #1 chk("R9 asserted", pme_n, 0);
        @(negedge clk); pme_en = 1'b0; #1 chk("R9 disabled", pme_n, 1);
        pme_en = 1'b1;
        // R8: clear coinciding with a new event
        cur_req = "R8";
        txq.delete(); push_ff(6); push_copies(16);
        send_frame(1);
        chk("R8 clear+event status", pme_status, 1); chk("R8 clear+event src", wake_src, 1);
        cur_req = "R9"; clear_pulse();
        #1 chk("R9 released", pme_n, 1);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule